// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block paces refresh for an asynchronous DRAM and runs its start-up sequence. After reset it stays quiet for the supply settling pause. It then asks the memory controller for a fixed number of initialization cycles, each of which contains a RAS assertion, before it declares the memory usable. In normal operation it asks for one CAS-before-RAS refresh per interval, so that every row is refreshed within the retention window. The interval is the retention time divided by the row count, converted to clock cycles and rounded down.

The controller carries out every cycle that the sequencer asks for, and it reports each completed cycle with a one-cycle grant pulse. The sequencer can also put the memory into self-refresh. It asks for an entry CBR cycle and tells the controller to keep RAS low afterwards. Once the minimum low time has elapsed it accepts an exit request. It then keeps RAS high for the minimum exit time. A build-time option decides what happens next: either the sequencer asks for a full burst over all rows before the memory is usable again, or it returns straight to distributed pacing. All times are given in nanoseconds and converted using the clock-period parameter. Minimum times are rounded up.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset release, `ref_req` and `mem_ready` stay low for exactly the power-on pause in cycles (rounded up). `ref_req` rises on the next cycle.
- R2: After the pause, `ref_req` stays high and `mem_ready` stays low until INIT_CYCLES grants have been counted. `mem_ready` rises, and `ref_req` falls, in the cycle after the last of those grants.
- R3: A `ref_gnt` pulse while `ref_req` is low has no effect. It does not count as an initialization cycle, and it does not move the next distributed request.
- R4: The first distributed request rises exactly one interval (floor of retention / rows, in cycles) after `mem_ready` rises. Later requests follow one interval apart. A request stays high until granted and falls in the cycle after the grant.
- R5: If a whole further interval elapses while a request is still pending, `refresh_missed` rises at that interval boundary and stays high until reset.
- R6: `sr_enter_req` while ready starts self-refresh entry. In the next cycle `ref_req` and `sr_keep_low` are high and `mem_ready` is low.
- R7: After the entry grant, `sr_keep_low` stays high. `sr_exit_ok` rises exactly the minimum low time (rounded up, in cycles) after the grant. An exit request made before that point is ignored.
- R8: An exit request while `sr_exit_ok` is high drops `sr_keep_low` in the next cycle. `ref_req` and `mem_ready` then stay low for the minimum exit time (rounded up, in cycles).
- R9: With the burst option (EXIT_BURST=1), `ref_req` rises after the exit time and `mem_ready` returns only after ROWS grants. Without it, `mem_ready` returns straight after the exit time.
- R10: While the memory is held in self-refresh, no refresh request is raised, however many intervals pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ref_gnt | input | 1 | One-cycle pulse: the controller completed the requested cycle |
| sr_enter_req | input | 1 | Level: ask to enter self-refresh |
| sr_exit_req | input | 1 | Level: ask to leave self-refresh |
| ref_req | output | 1 | Request for a RAS-containing refresh cycle |
| mem_ready | output | 1 | Memory usable for normal accesses |
| refresh_missed | output | 1 | Sticky flag: a refresh deadline passed while a request was pending |
| sr_keep_low | output | 1 | Controller holds RAS low after the current or past entry cycle |
| sr_exit_ok | output | 1 | Minimum self-refresh low time met; exit may be requested |

## Verification
Most internal faults here show up as an edge on `ref_req`, `mem_ready` or `sr_exit_ok` that arrives one or more cycles early or late. So the bench samples each such edge both in the cycle before it and in the cycle in which it is due. A grant counter that is off by one leaves `mem_ready` high or low one grant too soon, and this shows up at the eighth initialization grant or at the final burst grant. A pacing counter that is not cleared, or that counts outside normal operation, shows up as a stray `ref_req` during self-refresh, or as a request that comes early after a stray grant. Either appears within one interval.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP    = 3'd0,
      ST_INIT     = 3'd1,
      ST_RUN      = 3'd2,
      ST_SR_ENTRY = 3'd3,
      ST_SR_HOLD  = 3'd4,
      ST_SR_IDLE  = 3'd5,
      ST_SR_EXIT  = 3'd6,
      ST_BURST    = 3'd7
   } seq_state_e;

   // picoseconds to whole cycles, truncating (deadline-type intervals)
   function automatic longint ps_to_cyc_floor(longint span_ps, longint clk_ps);
      return span_ps / clk_ps;
   endfunction

   // picoseconds to whole cycles, rounding up (minimum-time constraints)
   function automatic longint ps_to_cyc_ceil(longint span_ps, longint clk_ps);
      return (span_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rfsh_phase_timer.sv
module rfsh_phase_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] elapsed
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)       elapsed <= '0;
      else if (elapsed != TOP) elapsed <= elapsed + 1'b1;
   end

   p_timer_steps_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && elapsed != TOP) |=> elapsed == $past(elapsed) + 1'b1);
endmodule

// File: rtl/rfsh_grant_cnt.sv
module rfsh_grant_cnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) count <= '0;
      else if (inc)      count <= count + 1'b1;
   end

   p_count_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/rfsh_pacer.sv
module rfsh_pacer #(
   parameter int unsigned INTV = 1562
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic gnt,
   output logic pend,
   output logic missed
);
   localparam int unsigned CW = $clog2(INTV + 1);
   localparam logic [CW-1:0] LAST = CW'(INTV - 1);

   logic [CW-1:0] cnt_q;
   logic          tick;

   generate
      if (INTV < 2) begin : g_bad_intv
         $error("refresh interval must be at least two cycles");
      end
   endgenerate

   assign tick = en && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) cnt_q <= '0;
      else if (tick)     cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) pend <= 1'b0;
      else               pend <= (pend && !gnt) || tick;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      missed <= 1'b0;
      else if (tick && pend && !gnt)   missed <= 1'b1;
   end

   p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pend && !gnt) |=> (pend || !en));
   p_missed_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      missed |=> missed);
   p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pend);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import dram_rfsh_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 10000,
   parameter int unsigned POWERUP_NS    = 200000,
   parameter int unsigned INIT_CYCLES   = 8,
   parameter int unsigned ROWS          = 512,
   parameter int unsigned RETENTION_NS  = 8000000,
   parameter int unsigned TRASS_NS      = 100000,
   parameter int unsigned TRPS_NS       = 110,
   parameter bit          EXIT_BURST    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_gnt,
   input  logic sr_enter_req,
   input  logic sr_exit_req,
   output logic ref_req,
   output logic mem_ready,
   output logic refresh_missed,
   output logic sr_keep_low,
   output logic sr_exit_ok
);
   localparam longint PWR_L   = ps_to_cyc_ceil(longint'(POWERUP_NS) * 1000, CLK_PERIOD_PS);
   localparam longint TRASS_L = ps_to_cyc_ceil(longint'(TRASS_NS) * 1000, CLK_PERIOD_PS);
   localparam longint TRPS_L  = ps_to_cyc_ceil(longint'(TRPS_NS) * 1000, CLK_PERIOD_PS);
   localparam longint INTV_L  = ps_to_cyc_floor((longint'(RETENTION_NS) * 1000) / ROWS,
                                                CLK_PERIOD_PS);
   localparam int unsigned PWR_CYC   = (PWR_L   < 1) ? 1 : int'(PWR_L);
   localparam int unsigned TRASS_CYC = (TRASS_L < 1) ? 1 : int'(TRASS_L);
   localparam int unsigned TRPS_CYC  = (TRPS_L  < 1) ? 1 : int'(TRPS_L);
   localparam int unsigned INTV_CYC  = int'(INTV_L);
   localparam int unsigned TMAX      = max3(PWR_CYC, TRASS_CYC, TRPS_CYC);
   localparam int unsigned TW        = $clog2(TMAX + 1);
   localparam int unsigned GMAX      = (INIT_CYCLES > ROWS) ? INIT_CYCLES : ROWS;
   localparam int unsigned GW        = $clog2(GMAX + 1);
   localparam logic [TW-1:0] PWR_LAST   = TW'(PWR_CYC - 1);
   localparam logic [TW-1:0] TRASS_LAST = TW'(TRASS_CYC - 1);
   localparam logic [TW-1:0] TRPS_LAST  = TW'(TRPS_CYC - 1);
   localparam logic [GW-1:0] INIT_LAST  = GW'(INIT_CYCLES - 1);
   localparam logic [GW-1:0] ROWS_LAST  = GW'(ROWS - 1);

   generate
      if (CLK_PERIOD_PS == 0) begin : g_bad_clk
         $error("clock period must be non-zero");
      end
      if (INIT_CYCLES < 1) begin : g_bad_init
         $error("at least one initialization cycle is required");
      end
      if (ROWS < 1) begin : g_bad_rows
         $error("row count must be non-zero");
      end
   endgenerate

   seq_state_e    state_q, state_d, exit_target;
   logic [TW-1:0] phase_t;
   logic [GW-1:0] gcount;
   logic          phase_chg, grant_ok, run_pend;

   // variant: what follows the self-refresh exit pause
   generate
      if (EXIT_BURST) begin : g_exit_burst
         assign exit_target = ST_BURST;
      end else begin : g_exit_direct
         assign exit_target = ST_RUN;
      end
   endgenerate

   assign grant_ok  = ref_gnt && ref_req;
   assign phase_chg = (state_d != state_q);

   rfsh_phase_timer #(.W(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (phase_chg),
      .elapsed (phase_t)
   );

   rfsh_grant_cnt #(.W(GW)) u_gcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_chg),
      .inc   (grant_ok),
      .count (gcount)
   );

   rfsh_pacer #(.INTV(INTV_CYC)) u_pacer (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (state_q == ST_RUN),
      .gnt    (ref_gnt),
      .pend   (run_pend),
      .missed (refresh_missed)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_PWRUP:    if (phase_t == PWR_LAST)                 state_d = ST_INIT;
         ST_INIT:     if (grant_ok && gcount == INIT_LAST)     state_d = ST_RUN;
         ST_RUN:      if (sr_enter_req)                        state_d = ST_SR_ENTRY;
         ST_SR_ENTRY: if (grant_ok)                            state_d = ST_SR_HOLD;
         ST_SR_HOLD:  if (phase_t == TRASS_LAST)               state_d = ST_SR_IDLE;
         ST_SR_IDLE:  if (sr_exit_req)                         state_d = ST_SR_EXIT;
         ST_SR_EXIT:  if (phase_t == TRPS_LAST)                state_d = exit_target;
         ST_BURST:    if (grant_ok && gcount == ROWS_LAST)     state_d = ST_RUN;
         default:                                              state_d = ST_PWRUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_PWRUP;
      else        state_q <= state_d;
   end

   assign ref_req     = (state_q == ST_INIT) || (state_q == ST_SR_ENTRY) ||
                        (state_q == ST_BURST) || ((state_q == ST_RUN) && run_pend);
   assign mem_ready   = (state_q == ST_RUN);
   assign sr_keep_low = (state_q == ST_SR_ENTRY) || (state_q == ST_SR_HOLD) ||
                        (state_q == ST_SR_IDLE);
   assign sr_exit_ok  = (state_q == ST_SR_IDLE);

   p_quiet_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PWRUP) |-> (!ref_req && !mem_ready));
   p_ready_on_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_ready) && $past(state_q == ST_INIT)) |-> $past(grant_ok));
   p_ready_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ready |-> !sr_keep_low);
   p_min_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_exit_ok) |-> ($past(phase_t) == TRASS_LAST));
   p_exit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SR_EXIT) |-> (!ref_req && !mem_ready && !sr_keep_low));
   p_no_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SR_HOLD || state_q == ST_SR_IDLE) |-> !ref_req);
   p_burst_to_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q == ST_BURST) && state_q == ST_RUN) |-> $past(grant_ok));
endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
   localparam int PWR   = 200;
   localparam int INTV  = 100;
   localparam int TRASS = 100;
   localparam int TRPS  = 11;
   localparam int ROWS  = 16;
   localparam int NINIT = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_gnt = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0;
   logic ref_req, mem_ready, refresh_missed, sr_keep_low, sr_exit_ok;
   logic nb_req, nb_ready, nb_missed, nb_keep, nb_ok;
   int   cyc = 0;
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   dram_refresh_seq #(
      .CLK_PERIOD_PS(10000), .POWERUP_NS(2000), .INIT_CYCLES(NINIT), .ROWS(ROWS),
      .RETENTION_NS(16050), .TRASS_NS(1000), .TRPS_NS(105), .EXIT_BURST(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_enter_req(sr_enter_req),
      .sr_exit_req(sr_exit_req), .ref_req(ref_req), .mem_ready(mem_ready),
      .refresh_missed(refresh_missed), .sr_keep_low(sr_keep_low), .sr_exit_ok(sr_exit_ok)
   );

   dram_refresh_seq #(
      .CLK_PERIOD_PS(10000), .POWERUP_NS(2000), .INIT_CYCLES(NINIT), .ROWS(ROWS),
      .RETENTION_NS(16050), .TRASS_NS(1000), .TRPS_NS(105), .EXIT_BURST(1'b0)
   ) dut_nb_i (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_enter_req(sr_enter_req),
      .sr_exit_req(sr_exit_req), .ref_req(nb_req), .mem_ready(nb_ready),
      .refresh_missed(nb_missed), .sr_keep_low(nb_keep), .sr_exit_ok(nb_ok)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at edge %0d: actual %b expected %b", tag, cyc, act, exp);
      end
   endtask

   task automatic wait_edge(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic pulse_gnt();
      ref_gnt = 1'b1;
      @(negedge clk);
      ref_gnt = 1'b0;
   endtask

   task automatic t_reset_state();
      repeat (3) @(negedge clk);
      chk("reset ref_req", ref_req, 1'b0);
      chk("reset mem_ready", mem_ready, 1'b0);
      chk("reset refresh_missed", refresh_missed, 1'b0);
      chk("reset sr_keep_low", sr_keep_low | sr_exit_ok, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_powerup();
      wait_edge(50);
      pulse_gnt();                              // R3: stray grant during the pause
      wait_edge(PWR - 1);
      chk("R1 req low before pause end", ref_req, 1'b0);
      chk("R1 ready low in pause", mem_ready, 1'b0);
      wait_edge(PWR);
      chk("R1 req at pause end", ref_req, 1'b1);
   endtask

   task automatic t_init(output int e_run);
      e_run = 0;
      for (int k = 1; k <= NINIT; k++) begin
         pulse_gnt();
         if (k < NINIT) begin
            chk("R2 ready low before last init grant (R3 stray not counted)", mem_ready, 1'b0);
            chk("R2 req held in init", ref_req, 1'b1);
         end else begin
            chk("R2 ready after last init grant", mem_ready, 1'b1);
            chk("R2 req drops after init", ref_req, 1'b0);
            e_run = cyc;
         end
      end
   endtask

   task automatic t_interval(input int e_run, output int t_next);
      int t;
      wait_edge(e_run + INTV - 1);
      chk("R4 no request before interval", ref_req, 1'b0);
      wait_edge(e_run + INTV);
      chk("R4 request at interval", ref_req, 1'b1);
      t = cyc;
      wait_edge(t + 5);
      chk("R4 request held until grant", ref_req, 1'b1);
      pulse_gnt();
      chk("R4 request drops after grant", ref_req, 1'b0);
      pulse_gnt();                              // R3: stray grant in normal operation
      wait_edge(t + INTV - 1);
      chk("R3 stray grant does not move request", ref_req, 1'b0);
      wait_edge(t + INTV);
      chk("R4 second request one interval later", ref_req, 1'b1);
      chk("R5 no miss when granted in time", refresh_missed, 1'b0);
      t_next = cyc;
   endtask

   task automatic t_missed(input int t2);
      wait_edge(t2 + INTV - 1);
      chk("R5 no miss before boundary", refresh_missed, 1'b0);
      wait_edge(t2 + INTV);
      chk("R5 miss at next boundary", refresh_missed, 1'b1);
      pulse_gnt();
      chk("R4 request cleared by grant", ref_req, 1'b0);
      chk("R5 miss flag sticky", refresh_missed, 1'b1);
   endtask

   task automatic t_self_refresh();
      int g, x, stray;
      sr_enter_req = 1'b1;
      @(negedge clk);
      sr_enter_req = 1'b0;
      chk("R6 entry request", ref_req, 1'b1);
      chk("R6 keep low on entry", sr_keep_low, 1'b1);
      chk("R6 not ready on entry", mem_ready, 1'b0);
      pulse_gnt();
      g = cyc;
      chk("R7 keep low after entry grant", sr_keep_low, 1'b1);
      wait_edge(g + 10);
      sr_exit_req = 1'b1;                       // R7: early exit request
      wait_edge(g + TRASS - 1);
      chk("R7 exit not allowed before min time", sr_exit_ok, 1'b0);
      chk("R7 keep low despite early exit", sr_keep_low, 1'b1);
      sr_exit_req = 1'b0;
      wait_edge(g + TRASS);
      chk("R7 exit allowed at min time", sr_exit_ok, 1'b1);
      stray = 0;
      for (int i = 0; i < 3 * INTV; i++) begin
         @(negedge clk);
         if (ref_req !== 1'b0 || sr_keep_low !== 1'b1) stray++;
      end
      n_checks++;
      if (stray != 0) begin
         n_fail++;
         $display("FAIL R10 requests in self-refresh: actual %0d expected 0", stray);
      end
      sr_exit_req = 1'b1;
      @(negedge clk);
      sr_exit_req = 1'b0;
      x = cyc;
      chk("R8 keep low drops on exit", sr_keep_low, 1'b0);
      wait_edge(x + TRPS - 1);
      chk("R8 no request in exit pause", ref_req, 1'b0);
      chk("R8 not ready in exit pause", mem_ready | nb_ready, 1'b0);
      wait_edge(x + TRPS);
      chk("R9 burst request after exit pause", ref_req, 1'b1);
      chk("R9 burst variant not ready yet", mem_ready, 1'b0);
      chk("R9 direct variant ready after pause", nb_ready, 1'b1);
      for (int k = 1; k <= ROWS; k++) begin
         pulse_gnt();
         if (k == ROWS - 1) chk("R9 not ready one grant short", mem_ready, 1'b0);
      end
      chk("R9 ready after full burst", mem_ready, 1'b1);
      chk("R9 burst request done", ref_req, 1'b0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      int e_run, t2;
      t_reset_state();
      t_powerup();
      t_init(e_run);
      t_interval(e_run, t2);
      t_missed(t2);
      t_self_refresh();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule